// File: doc/BRIEF.md
# Set-Associative Page Translation Buffer

This block is a small hardware cache of page table entries that sits in front of a page table walker. A virtual page number presented on the lookup port is split into a set index (its low bits) and a tag (its remaining upper bits). The tag is compared against every way of the selected set in parallel. On a hit, the physical page number and the permission bits come back combinationally in the same cycle, with no memory access.

On a miss, the block raises a miss signal so that the walker can fetch the entry from the page table in memory. When the walker returns the entry, it is installed through the fill port at the next clock edge. A fill goes into a free way if the set has one. If the set is full, a per-set round-robin pointer picks the victim. A fill whose tag is already present overwrites that entry in place, so a tag never appears twice in a set. A flush input invalidates every entry in one cycle.

With the default parameters the buffer holds 16 entries: 4 sets of 4 ways, 8-bit virtual page numbers and 6-bit physical page numbers.

Top module: `page_xlat_buffer`

## Requirements
- R1: The set index is `lk_vpn_i[1:0]` and the tag is `lk_vpn_i[7:2]`. With 64-byte pages, virtual address 0x03D4 gives page 0x0F (set 3, tag 0x03). A page with the same tag in another set, or with the same set and another tag, does not hit.
- R2: When `lk_valid_i` is high and the indexed set holds a valid entry with a matching tag, `lk_hit_o` is high in the same cycle. In that cycle `lk_ppn_o` and `lk_perm_o` carry the stored values. The permission field is {supervisor = bit 2, read = bit 1, write = bit 0}.
- R3: When `lk_valid_i` is high and no entry matches, `lk_miss_o` is high in the same cycle. `lk_hit_o` and `lk_miss_o` are never high together, and both are low while `lk_valid_i` is low.
- R4: A fill (`fill_valid_i` high, `flush_i` low) is installed at the clock edge. A lookup of the same page in the next cycle hits with the filled physical page and permissions.
- R5: A fill into a set that has an invalid way uses that invalid way. As a result, four distinct tags filled into an empty set all remain resident.
- R6: A fill into a full set replaces the way named by that set's round-robin pointer, then advances the pointer by one, wrapping around. The pointers start at way 0 and are independent per set.
- R7: A fill whose tag already hits in its set overwrites that way with the new contents. It creates no second copy and does not advance the pointer.
- R8: `flush_i` invalidates every entry at the clock edge. A fill in the same cycle as a flush is discarded.
- R9: A lookup in the same cycle as a fill to the same set reports the state from before the fill.
- R10: After reset, every entry is invalid and every round-robin pointer is at way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries at the next edge |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | 8 | Virtual page number to translate |
| lk_hit_o | output | 1 | Lookup found a valid matching entry |
| lk_miss_o | output | 1 | Lookup found no entry; walker must fetch it |
| lk_ppn_o | output | 6 | Physical page number on a hit |
| lk_perm_o | output | 3 | Permission bits on a hit {sup, read, write} |
| fill_valid_i | input | 1 | Install an entry returned by the walker |
| fill_vpn_i | input | 8 | Virtual page number of the filled entry |
| fill_ppn_i | input | 6 | Physical page number of the filled entry |
| fill_perm_i | input | 3 | Permission bits of the filled entry |

## Verification
Two pairs of functions can share a cycle: a lookup with a fill to the same set, and a fill with a flush. The bench drives the fill and the lookup of the same page together in one cycle. It expects a miss in that cycle and a hit with the new contents in the next one. It also raises a fill together with a flush and expects that page to miss afterwards, because the flush takes priority.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef struct packed {
      logic sup;
      logic rd;
      logic wr;
   } xlat_perm_t;

   localparam int PERM_W = $bits(xlat_perm_t);
endpackage

// File: rtl/xlat_way_match.sv
module xlat_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 6
) (
   input  logic [WAYS-1:0]            vld_i,
   input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
   input  logic [TAG_W-1:0]           tag_i,
   output logic [WAYS-1:0]            hits_o
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hits_o[w] = vld_i[w] && (tags_i[w] == tag_i);
   end
endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
   parameter int WAYS = 4,
   localparam int WB  = $clog2(WAYS)
) (
   input  logic [WAYS-1:0] vld_i,
   input  logic [WAYS-1:0] hits_i,
   input  logic [WB-1:0]   rr_i,
   output logic [WB-1:0]   way_o,
   output logic            evict_o
);
   logic [WB-1:0] hit_idx, free_idx;

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hits_i[w]) hit_idx = WB'(w);
         if (!vld_i[w]) free_idx = WB'(w);
      end
   end

   always_comb begin
      if (|hits_i) begin
         way_o   = hit_idx;
         evict_o = 1'b0;
      end else if (!(&vld_i)) begin
         way_o   = free_idx;
         evict_o = 1'b0;
      end else begin
         way_o   = rr_i;
         evict_o = 1'b1;
      end
   end
endmodule

// File: rtl/page_xlat_buffer.sv
module page_xlat_buffer #(
   parameter int VPN_W    = 8,
   parameter int SET_BITS = 2,
   parameter int WAYS     = 4,
   parameter int PPN_W    = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush_i,
   input  logic                      lk_valid_i,
   input  logic [VPN_W-1:0]          lk_vpn_i,
   output logic                      lk_hit_o,
   output logic                      lk_miss_o,
   output logic [PPN_W-1:0]          lk_ppn_o,
   output logic [xlat_pkg::PERM_W-1:0] lk_perm_o,
   input  logic                      fill_valid_i,
   input  logic [VPN_W-1:0]          fill_vpn_i,
   input  logic [PPN_W-1:0]          fill_ppn_i,
   input  logic [xlat_pkg::PERM_W-1:0] fill_perm_i
);
   import xlat_pkg::*;

   localparam int SETS  = 1 << SET_BITS;
   localparam int TAG_W = VPN_W - SET_BITS;
   localparam int WB    = $clog2(WAYS);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SET_BITS < 1 || SET_BITS >= VPN_W) begin : g_bad_sets
      $error("SET_BITS must leave at least one tag bit");
   end

   logic [SETS-1:0][WAYS-1:0]              vld_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
   logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]   ppn_q;
   logic [SETS-1:0][WAYS-1:0][PERM_W-1:0]  perm_q;
   logic [SETS-1:0][WB-1:0]                rr_q;

   // lookup path
   logic [SET_BITS-1:0] lk_set;
   logic [TAG_W-1:0]    lk_tag;
   logic [WAYS-1:0]     lk_hits;

   assign lk_set = lk_vpn_i[SET_BITS-1:0];
   assign lk_tag = lk_vpn_i[VPN_W-1:SET_BITS];

   xlat_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
      .vld_i (vld_q[lk_set]),
      .tags_i(tag_q[lk_set]),
      .tag_i (lk_tag),
      .hits_o(lk_hits)
   );

   always_comb begin
      lk_ppn_o  = '0;
      lk_perm_o = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_hits[w]) begin
            lk_ppn_o  = lk_ppn_o  | ppn_q[lk_set][w];
            lk_perm_o = lk_perm_o | perm_q[lk_set][w];
         end
      end
   end

   assign lk_hit_o  = lk_valid_i && (|lk_hits);
   assign lk_miss_o = lk_valid_i && !(|lk_hits);

   // fill path
   logic [SET_BITS-1:0] fl_set;
   logic [TAG_W-1:0]    fl_tag;
   logic [WAYS-1:0]     fl_hits;
   logic [WB-1:0]       fl_way;
   logic                fl_evict;
   logic                fl_go;

   assign fl_set = fill_vpn_i[SET_BITS-1:0];
   assign fl_tag = fill_vpn_i[VPN_W-1:SET_BITS];
   assign fl_go  = fill_valid_i && !flush_i;

   xlat_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
      .vld_i (vld_q[fl_set]),
      .tags_i(tag_q[fl_set]),
      .tag_i (fl_tag),
      .hits_o(fl_hits)
   );

   xlat_victim_pick #(.WAYS(WAYS)) u_victim (
      .vld_i  (vld_q[fl_set]),
      .hits_i (fl_hits),
      .rr_i   (rr_q[fl_set]),
      .way_o  (fl_way),
      .evict_o(fl_evict)
   );

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic wr_en;
      assign wr_en = fl_go && (fl_set == SET_BITS'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[s] <= '0;
            rr_q[s]  <= '0;
         end else if (flush_i) begin
            vld_q[s] <= '0;
         end else if (wr_en) begin
            vld_q[s][fl_way] <= 1'b1;
            if (fl_evict) rr_q[s] <= rr_q[s] + WB'(1);
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en) begin
            tag_q[s][fl_way]  <= fl_tag;
            ppn_q[s][fl_way]  <= fill_ppn_i;
            perm_q[s][fl_way] <= fill_perm_i;
         end
      end
   end
endmodule

// File: rtl/page_xlat_buffer_chk.sv
module page_xlat_buffer_chk #(
   parameter int VPN_W = 8,
   parameter int PPN_W = 6,
   parameter int PW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush_i,
   input logic             lk_valid_i,
   input logic [VPN_W-1:0] lk_vpn_i,
   input logic             lk_hit_o,
   input logic             lk_miss_o,
   input logic [PPN_W-1:0] lk_ppn_o,
   input logic [PW-1:0]    lk_perm_o,
   input logic             fill_valid_i,
   input logic [VPN_W-1:0] fill_vpn_i,
   input logic [PPN_W-1:0] fill_ppn_i,
   input logic [PW-1:0]    fill_perm_i
);
   assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit_o && lk_miss_o));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid_i |-> (!lk_hit_o && !lk_miss_o));

   assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !lk_hit_o);

   assert_fill_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid_i && !flush_i) |=>
         (!(lk_valid_i && lk_vpn_i == $past(fill_vpn_i)) ||
          (lk_hit_o && lk_ppn_o == $past(fill_ppn_i) && lk_perm_o == $past(fill_perm_i))));
endmodule

bind page_xlat_buffer page_xlat_buffer_chk #(
   .VPN_W(VPN_W), .PPN_W(PPN_W), .PW(xlat_pkg::PERM_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
   .lk_valid_i(lk_valid_i), .lk_vpn_i(lk_vpn_i),
   .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o),
   .lk_ppn_o(lk_ppn_o), .lk_perm_o(lk_perm_o),
   .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i),
   .fill_ppn_i(fill_ppn_i), .fill_perm_i(fill_perm_i)
);

// File: tb/page_xlat_buffer_test.sv
module page_xlat_buffer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush_i = 1'b0;
   logic       lk_valid_i = 1'b0;
   logic [7:0] lk_vpn_i = '0;
   logic       lk_hit_o, lk_miss_o;
   logic [5:0] lk_ppn_o;
   logic [2:0] lk_perm_o;
   logic       fill_valid_i = 1'b0;
   logic [7:0] fill_vpn_i = '0;
   logic [5:0] fill_ppn_i = '0;
   logic [2:0] fill_perm_i = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   page_xlat_buffer uut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // caller is at a negedge; returns at the next negedge
   task automatic fill_cyc(logic [7:0] vpn, logic [5:0] ppn, logic [2:0] perm);
      fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_perm_i = perm;
      @(negedge clk);
      fill_valid_i = 1'b0;
   endtask

   task automatic look(string req, logic [7:0] vpn, bit exp_hit,
                       logic [5:0] exp_ppn, logic [2:0] exp_perm);
      lk_valid_i = 1'b1; lk_vpn_i = vpn;
      #2;
      chk({req, " hit"}, 32'(lk_hit_o), 32'(exp_hit));
      chk({req, " miss"}, 32'(lk_miss_o), 32'(!exp_hit));
      if (exp_hit) begin
         chk({req, " ppn"}, 32'(lk_ppn_o), 32'(exp_ppn));
         chk({req, " perm"}, 32'(lk_perm_o), 32'(exp_perm));
      end
      @(negedge clk);
      lk_valid_i = 1'b0;
   endtask

   task automatic do_flush();
      flush_i = 1'b1;
      @(negedge clk);
      flush_i = 1'b0;
   endtask

   function automatic logic [7:0] vp(logic [5:0] tag, logic [1:0] set);
      return {tag, set};
   endfunction

   task automatic t_reset();
      look("R10 empty after reset", 8'h00, 0, '0, '0);
      #2 chk("R3 idle quiet", 32'({lk_hit_o, lk_miss_o}), 32'd0);
   endtask

   task automatic t_reference();
      fill_cyc(8'h0F, 6'h0D, 3'b011);
      look("R1 va 0x03D4", 8'(16'h03D4 >> 6), 1, 6'h0D, 3'b011);
      look("R1 va 0x0020", 8'(16'h0020 >> 6), 0, '0, '0);
      look("R1 other set same tag", vp(6'h03, 2'd2), 0, '0, '0);
      look("R1 same set other tag", 8'h1F, 0, '0, '0);
      look("R2 perm layout", 8'h0F, 1, 6'h0D, 3'b011);
   endtask

   task automatic t_round_robin();
      for (int t = 1; t <= 4; t++) fill_cyc(vp(6'(t), 2'd1), 6'(8'h10 + t), 3'b110);
      for (int t = 1; t <= 4; t++) look("R5 free ways used", vp(6'(t), 2'd1), 1, 6'(8'h10 + t), 3'b110);
      fill_cyc(vp(6'd5, 2'd1), 6'h15, 3'b010);
      look("R6 R10 way0 evicted first", vp(6'd1, 2'd1), 0, '0, '0);
      look("R6 new entry", vp(6'd5, 2'd1), 1, 6'h15, 3'b010);
      fill_cyc(vp(6'd6, 2'd1), 6'h16, 3'b010);
      look("R6 way1 evicted second", vp(6'd2, 2'd1), 0, '0, '0);
      look("R6 way3 kept", vp(6'd4, 2'd1), 1, 6'h14, 3'b110);
      // overwrite existing tag 3 (way 2)
      fill_cyc(vp(6'd3, 2'd1), 6'h2A, 3'b001);
      look("R7 overwrite in place", vp(6'd3, 2'd1), 1, 6'h2A, 3'b001);
      fill_cyc(vp(6'd7, 2'd1), 6'h17, 3'b000);
      look("R7 pointer not advanced", vp(6'd3, 2'd1), 0, '0, '0);
      look("R7 way3 survives", vp(6'd4, 2'd1), 1, 6'h14, 3'b110);
      // set 2 has its own pointer still at way 0
      for (int t = 1; t <= 5; t++) fill_cyc(vp(6'(t + 8), 2'd2), 6'(t + 8), 3'b100);
      look("R6 per-set pointer evicts way0", vp(6'd9, 2'd2), 0, '0, '0);
      look("R6 per-set pointer keeps way3", vp(6'd12, 2'd2), 1, 6'd12, 3'b100);
   endtask

   task automatic t_same_cycle();
      // set 3 currently holds only tag 0x03; fill and look up tag 0x20 together
      fill_valid_i = 1'b1; fill_vpn_i = vp(6'h20, 2'd3); fill_ppn_i = 6'h3C; fill_perm_i = 3'b111;
      lk_valid_i = 1'b1; lk_vpn_i = vp(6'h20, 2'd3);
      #2;
      chk("R9 lookup sees pre-fill", 32'(lk_miss_o), 32'd1);
      chk("R9 no hit in fill cycle", 32'(lk_hit_o), 32'd0);
      @(negedge clk);
      fill_valid_i = 1'b0; lk_valid_i = 1'b0;
      look("R4 visible next cycle", vp(6'h20, 2'd3), 1, 6'h3C, 3'b111);
   endtask

   task automatic t_flush();
      flush_i = 1'b1;
      fill_valid_i = 1'b1; fill_vpn_i = vp(6'h30, 2'd0); fill_ppn_i = 6'h01; fill_perm_i = 3'b010;
      @(negedge clk);
      flush_i = 1'b0; fill_valid_i = 1'b0;
      look("R8 fill during flush dropped", vp(6'h30, 2'd0), 0, '0, '0);
      look("R8 old entry gone", 8'h0F, 0, '0, '0);
      look("R8 set1 gone", vp(6'd4, 2'd1), 0, '0, '0);
      fill_cyc(vp(6'h30, 2'd0), 6'h01, 3'b010);
      look("R4 refill after flush", vp(6'h30, 2'd0), 1, 6'h01, 3'b010);
      do_flush();
      look("R8 plain flush", vp(6'h30, 2'd0), 0, '0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reference();
      t_round_robin();
      t_same_cycle();
      t_flush();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule